// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block is the digital control side of a multichannel successive-approximation converter that runs from an external conversion clock. A rising edge on the start input launches a sequence over the channels enabled in a 4-bit mask. Channels are taken in ascending index order. Each channel occupies a frame of sixteen falling edges of the conversion clock.

During each frame the block drives the busy, end-of-conversion and first-data status outputs at fixed edge counts. It stores one 14-bit result per converted channel into a bank of four data registers, and it lets a host read those registers with a strobe. The read address moves forward by one register on every read.

The analog conversion itself is not modelled. The result for each channel is taken from a per-channel sample input at the moment that channel completes. The conversion clock is asynchronous to the system clock, so it is resynchronized and edge-detected before use. Every output is a register in the system clock domain.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A rising edge on `conv_start` while idle with a nonzero `ch_mask` sets `busy` high on the next system clock edge. The mask is captured at that moment.
- R2: A conversion-clock falling edge detected within `GUARD_CYCLES` system cycles after an accepted start sets `guard_viol` high. The flag stays high until the next accepted start clears it.
- R3: Each selected channel takes exactly 16 conversion-clock falling edges. Channels are converted in ascending index order. The k-th converted channel's result goes to data register k, where register 1 has index 0.
- R4: On the 14th falling edge of the first channel's frame, the read address returns to register 1 and `first_data` goes high.
- R5: On the 15th falling edge of every frame, `eoc_n` goes low and the current channel's `ch_sample` field is stored. Field c occupies bits [14c+13:14c].
- R6: On the 16th falling edge of every frame, `eoc_n` returns high.
- R7: On the 15th falling edge of the last selected channel's frame, `busy` goes low together with `eoc_n`. On earlier frames `busy` stays high.
- R8: In each system cycle with `rd_strobe` high, `rd_data` is loaded with the addressed register. The address then advances by one and wraps from register 4 back to register 1. Reads are allowed while `eoc_n` is low.
- R9: `first_data` is high only while register 1 is addressed. A read clears it.
- R10: A `conv_start` edge that arrives while `busy` is high is ignored. This includes any change of `ch_mask` that accompanies it.
- R11: A `conv_start` edge with `ch_mask` equal to zero is ignored.
- R12: After reset, `busy`=0, `eoc_n`=1, `first_data`=0, `guard_viol`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Sequence start; acts on its rising edge |
| conv_clk | input | 1 | External conversion clock; idles high |
| ch_mask | input | 4 | Channel-select mask, bit c enables channel c |
| ch_sample | input | 56 | Per-channel results, 14 bits per channel |
| rd_strobe | input | 1 | Read request, one read per high cycle |
| busy | output | 1 | Sequence in progress |
| eoc_n | output | 1 | End of conversion, active low |
| first_data | output | 1 | Register 1 is addressed |
| rd_data | output | 14 | Result of the last read |
| guard_viol | output | 1 | Conversion clock fell too soon after start |

## Verification
The hardest situation to reach is the one in which the read address has to be pulled back to register 1 while a previous sequence left it elsewhere. The vector table orders masks so that an earlier sequence reads only part of the bank before the next one starts. Later reads then prove that the address restart on the 14th edge took effect. A second hard case is a start edge, carrying a different mask, that arrives in the middle of a frame. Directed tests raise it after the fifth conversion-clock edge and count the remaining frames. Another directed test lets the conversion clock fall one cycle after start to trip the guard window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_TAIL = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cclk_edge_det.sv
module cclk_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], async_in};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign fall_o = st_q.prev & ~st_q.sync[SYNC_STAGES-1];
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int FRAME_EDGES  = 16,
    parameter int GUARD_CYCLES = 10,
    localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              fall_evt,
    input  logic [NUM_CH-1:0] ch_mask,
    output logic              busy,
    output logic              eoc_n,
    output logic              guard_viol,
    output logic              wr_en,
    output logic [CH_W-1:0]   wr_idx,
    output logic [CH_W-1:0]   ch_idx,
    output logic              ptr_rst
);
    localparam int EDGE_W  = $clog2(FRAME_EDGES + 1);
    localparam int GUARD_W = $clog2(GUARD_CYCLES + 1);
    localparam logic [EDGE_W-1:0]  FD_EDGE   = EDGE_W'(FRAME_EDGES - 2);
    localparam logic [EDGE_W-1:0]  EOC_EDGE  = EDGE_W'(FRAME_EDGES - 1);
    localparam logic [EDGE_W-1:0]  LAST_EDGE = EDGE_W'(FRAME_EDGES);
    localparam logic [GUARD_W-1:0] GUARD_LD  = GUARD_W'(GUARD_CYCLES);

    typedef struct packed {
        seq_state_e         state;
        logic               start_prev;
        logic [NUM_CH-1:0]  mask;
        logic [CH_W-1:0]    ch;
        logic [CH_W-1:0]    slot;
        logic [EDGE_W-1:0]  edges;
        logic               first;
        logic [GUARD_W-1:0] guard;
        logic               busy;
        logic               eoc_n;
        logic               viol;
    } fsm_t;

    fsm_t st_d, st_q;

    logic              start_rise;
    logic [EDGE_W-1:0] edge_num;
    logic [CH_W:0]     pick_first;
    logic [CH_W:0]     pick_next;

    function automatic logic [CH_W:0] find_ch(input logic [NUM_CH-1:0] m, input int from);
        logic [CH_W:0] r;
        r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (i >= from && m[i]) r = {1'b1, CH_W'(i)};
        end
        return r;
    endfunction

    always_comb begin
        st_d       = st_q;
        wr_en      = 1'b0;
        ptr_rst    = 1'b0;
        start_rise = conv_start & ~st_q.start_prev;
        edge_num   = st_q.edges + 1'b1;
        pick_first = find_ch(ch_mask, 0);
        pick_next  = find_ch(st_q.mask, int'(st_q.ch) + 1);
        st_d.start_prev = conv_start;
        if (st_q.guard != '0) st_d.guard = st_q.guard - 1'b1;

        unique case (st_q.state)
            ST_IDLE: begin
                if (start_rise && (|ch_mask)) begin
                    st_d.state = ST_CONV;
                    st_d.busy  = 1'b1;
                    st_d.mask  = ch_mask;
                    st_d.ch    = pick_first[CH_W-1:0];
                    st_d.slot  = '0;
                    st_d.edges = '0;
                    st_d.first = 1'b1;
                    st_d.guard = GUARD_LD;
                    st_d.viol  = 1'b0;
                end
            end
            ST_CONV: begin
                if (fall_evt) begin
                    if (st_q.guard != '0) st_d.viol = 1'b1;
                    st_d.edges = edge_num;
                    if (edge_num == FD_EDGE && st_q.first) ptr_rst = 1'b1;
                    if (edge_num == EOC_EDGE) begin
                        st_d.eoc_n = 1'b0;
                        wr_en      = 1'b1;
                        st_d.slot  = st_q.slot + 1'b1;
                        if (!pick_next[CH_W]) begin
                            st_d.busy  = 1'b0;
                            st_d.state = ST_TAIL;
                        end
                    end
                    if (edge_num == LAST_EDGE) begin
                        st_d.eoc_n = 1'b1;
                        st_d.edges = '0;
                        st_d.first = 1'b0;
                        st_d.ch    = pick_next[CH_W-1:0];
                    end
                end
            end
            ST_TAIL: begin
                if (fall_evt) begin
                    st_d.eoc_n = 1'b1;
                    st_d.edges = '0;
                    st_d.first = 1'b0;
                    st_d.state = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.state      <= ST_IDLE;
            st_q.eoc_n      <= 1'b1;
            st_q.start_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.busy;
    assign eoc_n      = st_q.eoc_n;
    assign guard_viol = st_q.viol;
    assign wr_idx     = st_q.slot;
    assign ch_idx     = st_q.ch;

    // R1
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(start_rise));
    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $fell(st_q.eoc_n));
    // R5
    eoc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.eoc_n) |-> $past(fall_evt));
    // R2
    viol_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.viol) |-> $past(fall_evt && st_q.guard != '0));
    // R3
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.edges <= LAST_EDGE);
endmodule

// File: rtl/result_bank.sv
module result_bank #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 14,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ptr_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              first_data
);
    localparam logic [CH_W-1:0] PTR_MAX = CH_W'(NUM_CH - 1);

    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] regs;
        logic [CH_W-1:0]               ptr;
        logic [DATA_W-1:0]             rd_data;
        logic                          first;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.regs[wr_idx] = wr_data;
        if (rd_en) begin
            st_d.rd_data = st_q.regs[st_q.ptr];
            st_d.ptr     = (st_q.ptr == PTR_MAX) ? '0 : st_q.ptr + 1'b1;
            st_d.first   = 1'b0;
        end
        if (ptr_rst) begin
            st_d.ptr   = '0;
            st_d.first = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data    = st_q.rd_data;
    assign first_data = st_q.first;

    // R9
    first_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.first |-> st_q.ptr == '0);
    // R4
    ptr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> (st_q.first && st_q.ptr == '0));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int NUM_CH       = 4,
    parameter int DATA_W       = 14,
    parameter int FRAME_EDGES  = 16,
    parameter int GUARD_CYCLES = 10,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     conv_start,
    input  logic                     conv_clk,
    input  logic [NUM_CH-1:0]        ch_mask,
    input  logic [NUM_CH*DATA_W-1:0] ch_sample,
    input  logic                     rd_strobe,
    output logic                     busy,
    output logic                     eoc_n,
    output logic                     first_data,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     guard_viol
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              fall_evt;
    logic              wr_en;
    logic              ptr_rst;
    logic [CH_W-1:0]   wr_idx;
    logic [CH_W-1:0]   ch_idx;
    logic [DATA_W-1:0] wr_data;

    cclk_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (conv_clk),
        .fall_o   (fall_evt)
    );

    seq_fsm #(
        .NUM_CH       (NUM_CH),
        .FRAME_EDGES  (FRAME_EDGES),
        .GUARD_CYCLES (GUARD_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .fall_evt   (fall_evt),
        .ch_mask    (ch_mask),
        .busy       (busy),
        .eoc_n      (eoc_n),
        .guard_viol (guard_viol),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .ch_idx     (ch_idx),
        .ptr_rst    (ptr_rst)
    );

    assign wr_data = ch_sample[int'(ch_idx)*DATA_W +: DATA_W];

    result_bank #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .ptr_rst    (ptr_rst),
        .rd_en      (rd_strobe),
        .rd_data    (rd_data),
        .first_data (first_data)
    );
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    localparam int GUARD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0;
    logic        conv_clk = 1'b1;
    logic [3:0]  ch_mask = '0;
    logic [55:0] ch_sample = '0;
    logic        rd_strobe = 1'b0;
    logic        busy, eoc_n, first_data, guard_viol;
    logic [13:0] rd_data;

    int checks = 0;
    int errors = 0;

    adc_seq_ctrl #(.GUARD_CYCLES(GUARD)) dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_clk(conv_clk),
        .ch_mask(ch_mask), .ch_sample(ch_sample), .rd_strobe(rd_strobe),
        .busy(busy), .eoc_n(eoc_n), .first_data(first_data),
        .rd_data(rd_data), .guard_viol(guard_viol)
    );

    always #10 clk = ~clk;

    localparam logic [3:0]  VMASK [6] = '{4'b0110, 4'b1111, 4'b0101, 4'b1000, 4'b0001, 4'b1011};
    localparam logic [13:0] VBASE [6] = '{14'h1234, 14'h0abc, 14'h3f01, 14'h2222, 14'h0007, 14'h1a5a};
    localparam int          VCNT  [6] = '{2, 4, 2, 1, 1, 3};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] samp(input logic [13:0] base, input int c);
        return base + 14'(c * 14'h0411);
    endfunction

    task automatic load(input logic [3:0] m, input logic [13:0] base);
        ch_mask = m;
        for (int c = 0; c < 4; c++) ch_sample[c*14 +: 14] = samp(base, c);
    endtask

    task automatic pulse_start();
        @(negedge clk) conv_start = 1'b1;
        @(negedge clk) conv_start = 1'b0;
    endtask

    task automatic cfall();
        @(negedge clk) conv_clk = 1'b0;
        repeat (4) @(negedge clk);
        conv_clk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(output logic [13:0] v);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        v = rd_data;
    endtask

    task automatic run_seq(input logic [3:0] m, input logic [13:0] base,
                           input int frames, input int nreads);
        int sel[4];
        int n = 0;
        logic [13:0] v;
        for (int c = 0; c < 4; c++) if (m[c]) begin sel[n] = c; n++; end
        load(m, base);
        pulse_start();
        chk("R1 busy after start", busy, 1);
        repeat (GUARD + 4) @(negedge clk);
        for (int f = 0; f < frames; f++) begin
            for (int e = 1; e <= 16; e++) begin
                cfall();
                if (f == 0 && e == 14) chk("R4 first_data on edge 14", first_data, 1);
                if (e == 14) chk("R3 busy mid frame", busy, 1);
                if (e == 15) begin
                    chk("R5 eoc_n low on edge 15", eoc_n, 0);
                    chk("R7 busy on edge 15", busy, (f != frames - 1) ? 1 : 0);
                end
                if (e == 16) chk("R6 eoc_n high on edge 16", eoc_n, 1);
            end
        end
        chk("R2 no violation with late clock", guard_viol, 0);
        for (int k = 0; k < nreads; k++) begin
            do_read(v);
            chk("R8 read data", v, samp(base, sel[k % n]));
            if (k == 0) chk("R9 first_data cleared by read", first_data, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [13:0] v;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 busy", busy, 0);
        chk("R12 eoc_n", eoc_n, 1);
        chk("R12 first_data", first_data, 0);
        chk("R12 guard_viol", guard_viol, 0);
        chk("R12 rd_data", rd_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 6; i++) run_seq(VMASK[i], VBASE[i], VCNT[i], VCNT[i]);

        // R8 pointer wrap after the fourth register
        run_seq(4'b1111, 14'h0155, 4, 5);

        // R11 empty mask start ignored
        load(4'b0000, 14'h0100);
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R11 busy stays low", busy, 0);
        cfall();
        chk("R11 eoc_n unchanged", eoc_n, 1);

        // R10 start during busy ignored, mask change ignored
        load(4'b0011, 14'h0200);
        pulse_start();
        repeat (GUARD + 4) @(negedge clk);
        for (int e = 1; e <= 5; e++) cfall();
        ch_mask = 4'b1111;
        pulse_start();
        for (int e = 6; e <= 31; e++) cfall();
        chk("R10 busy low after two frames", busy, 0);
        cfall();
        chk("R10 eoc_n restored", eoc_n, 1);
        for (int e = 1; e <= 16; e++) cfall();
        chk("R10 no extra frame busy", busy, 0);
        chk("R10 no extra frame eoc_n", eoc_n, 1);
        do_read(v);
        chk("R10 register 1", v, samp(14'h0200, 0));
        do_read(v);
        chk("R10 register 2", v, samp(14'h0200, 1));

        // R8 read while eoc_n low
        load(4'b0100, 14'h0333);
        pulse_start();
        repeat (GUARD + 4) @(negedge clk);
        for (int e = 1; e <= 15; e++) cfall();
        chk("R8 eoc_n low before read", eoc_n, 0);
        do_read(v);
        chk("R8 read during eoc low", v, samp(14'h0333, 2));
        chk("R8 eoc_n still low", eoc_n, 0);
        cfall();

        // R2 guard window violation and its clearing
        load(4'b0001, 14'h0044);
        pulse_start();
        cfall();
        chk("R2 early edge flagged", guard_viol, 1);
        for (int e = 2; e <= 16; e++) cfall();
        chk("R2 flag held after sequence", guard_viol, 1);
        pulse_start();
        repeat (2) @(negedge clk);
        chk("R2 flag cleared by start", guard_viol, 0);
        repeat (GUARD + 4) @(negedge clk);
        for (int e = 1; e <= 16; e++) cfall();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule